// File: doc/BRIEF.md
# Bitmap VGA Display Controller

This block produces a fixed 640x480, 60 Hz VGA raster and fills it from a chunky bitmap held in an external video memory. A 3-bit mode word selects pixel width doubling (320 columns), line doubling (240 rows) and pixel depth (4-bit or 8-bit). Each pixel value is an index into a 256-entry table of 12-bit colours. The table is loaded through its own write port and drives 4-bit red, green and blue outputs.

While one scan line is being shown, the next source line is copied from memory into one half of a two-bank line buffer. One byte is requested per cycle, and data returns in order with a valid strobe. Display reads never wait on memory. The mode word is taken once per frame, at the start of the last scan line, which is also the cycle in which the fetch of line 0 begins. A mode change therefore never splits a frame.

Top module: `vga_bitmap_ctrl`

## Requirements
- R1: A line lasts HACT+HFP+HSW+HBP clocks. hsync_n_o is low (active) for exactly HSW consecutive clocks, starting HACT+HFP clocks after the first active pixel of the line.
- R2: A frame lasts VACT+VFP+VSW+VBP lines. vsync_n_o is low (active) for VSW lines, starting at line VACT+VFP, and it changes only at line boundaries.
- R3: Outside the HACT x VACT active area, red_o, green_o and blue_o are all zero.
- R4: With mode bit 2 = 1 and bits 1:0 = 0, the pixel at (x,y) is the byte at address y*HACT + x.
- R5: With mode bit 2 = 0 (4-bit pixels), each byte holds two pixels and its upper nibble (bits 7:4) is shown first. Bytes per source line are halved, and the index is zero-extended to 8 bits.
- R6: With mode bit 0 = 1, each source pixel is shown for two consecutive clocks and a source line holds HACT/2 pixels.
- R7: With mode bit 1 = 1, source line y/2 is shown on scan lines y and y+1, which gives VACT/2 source lines.
- R8: The output colour is the palette entry selected by the pixel index, with red = bits 11:8, green = 7:4 and blue = 3:0.
- R9: A palette write presented in the cycle before a pixel leaves the colour outputs is already visible in that pixel when it targets that pixel's entry.
- R10: The mode word is sampled once per frame, at the first clock of the last scan line. A change during a frame takes effect on the next frame.
- R11: In reset the colour outputs are zero and both syncs are high. After reset the outputs lag the raster position by two clocks, and the raster starts at the first clock of the last line.
- R12: Each frame issues exactly VACT * bytes-per-line memory reads. Within one line the read addresses are consecutive, starting at source_line * bytes-per-line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | bit0 double width, bit1 double height, bit2 8-bit pixels |
| pal_we_i | input | 1 | Palette write enable |
| pal_waddr_i | input | 8 | Palette entry to write |
| pal_wdata_i | input | 12 | Colour written (R 11:8, G 7:4, B 3:0) |
| mem_req_o | output | 1 | Video memory read request, one byte |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_rvalid_i | input | 1 | Read data valid, in request order |
| mem_rdata_i | input | 8 | Read data byte |
| red_o | output | 4 | Red component |
| green_o | output | 4 | Green component |
| blue_o | output | 4 | Blue component |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |

## Verification
A palette write and the colour lookup for a displayed pixel can land in the same cycle on the same entry. The bench provokes this on one whole scan line. On every active pixel it rewrites exactly the entry that the next outgoing pixel uses, one cycle before that pixel leaves. It then requires the new colour on that very pixel (R9). Frame-start mode sampling and a line fetch also share a cycle. A mode change is therefore driven in the middle of a frame, and the bench requires the frame to finish in the old mode and the read count to match that mode.

// File: rtl/vbm_pkg.sv
package vbm_pkg;

  // Packed so that a 3-bit mode word casts directly: {bpp8, vdbl, hdbl}
  typedef struct packed {
    logic bpp8;
    logic vdbl;
    logic hdbl;
  } vmode_t;

  // Bytes of video memory that make up one source line
  function automatic int unsigned line_bytes(int unsigned hact, vmode_t m);
    int unsigned w;
    w = m.hdbl ? hact / 2 : hact;
    return m.bpp8 ? w : w / 2;
  endfunction

  // Source row shown on scan line y
  function automatic int unsigned src_row(int unsigned y, vmode_t m);
    return m.vdbl ? y / 2 : y;
  endfunction

  // Source column shown at raster column x
  function automatic int unsigned src_col(int unsigned x, vmode_t m);
    return m.hdbl ? x / 2 : x;
  endfunction

  // Byte within the source line holding source column sx
  function automatic int unsigned byte_of_col(int unsigned sx, vmode_t m);
    return m.bpp8 ? sx : sx / 2;
  endfunction

  // Palette index from a buffered byte; even columns take the upper nibble
  function automatic logic [7:0] index_of(logic [7:0] b, logic col_lsb, vmode_t m);
    if (m.bpp8) return b;
    return {4'h0, col_lsb ? b[3:0] : b[7:4]};
  endfunction

endpackage

// File: rtl/vbm_timing.sv
module vbm_timing #(
  parameter int HACT = 640,
  parameter int HFP  = 16,
  parameter int HSW  = 96,
  parameter int HBP  = 48,
  parameter int VACT = 480,
  parameter int VFP  = 10,
  parameter int VSW  = 2,
  parameter int VBP  = 33,
  localparam int HTOT = HACT + HFP + HSW + HBP,
  localparam int VTOT = VACT + VFP + VSW + VBP,
  localparam int HCW  = $clog2(HTOT),
  localparam int VCW  = $clog2(VTOT)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [HCW-1:0] h_cnt_o,
  output logic [VCW-1:0] v_cnt_o,
  output logic           line_start_o,
  output logic           last_line_o,
  output logic           disp_act_o,
  output logic           hs_n_o,
  output logic           vs_n_o
);

  logic [HCW-1:0] h_q;
  logic [VCW-1:0] v_q;
  logic           h_last;

  assign h_last = (h_q == HCW'(HTOT - 1));
  assign last_line_o = (v_q == VCW'(VTOT - 1));

  // Raster restarts at the head of the last line so line 0 gets fetched
  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= '0;
      v_q <= VCW'(VTOT - 1);
    end else if (h_last) begin
      h_q <= '0;
      v_q <= last_line_o ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_cnt_o      = h_q;
  assign v_cnt_o      = v_q;
  assign line_start_o = (h_q == '0);
  assign disp_act_o   = (h_q < HCW'(HACT)) && (v_q < VCW'(VACT));
  assign hs_n_o = !((h_q >= HCW'(HACT + HFP)) && (h_q < HCW'(HACT + HFP + HSW)));
  assign vs_n_o = !((v_q >= VCW'(VACT + VFP)) && (v_q < VCW'(VACT + VFP + VSW)));

  // Width of each hsync pulse, measured independently of the decode
  logic [HCW-1:0] hs_lo_q;
  always_ff @(posedge clk) begin
    if (rst) hs_lo_q <= '0;
    else     hs_lo_q <= hs_n_o ? '0 : hs_lo_q + 1'b1;
  end

  // R1
  hsync_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_n_o) |-> (hs_lo_q == HCW'(HSW)));

  // R2
  vsync_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(vs_n_o) || $fell(vs_n_o)) |-> line_start_o);

endmodule

// File: rtl/vbm_fetch.sv
module vbm_fetch
  import vbm_pkg::*;
#(
  parameter int HACT   = 640,
  parameter int VCW    = 10,
  parameter int ADDR_W = 19,
  parameter int LBA    = 11,
  localparam int CW    = $clog2(HACT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start_i,
  input  logic [VCW-1:0]    next_v_i,
  input  logic              fetch_en_i,
  input  vmode_t            mode_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              lb_we_o,
  output logic [LBA-1:0]    lb_waddr_o,
  output logic [7:0]        lb_wdata_o
);

  logic              act_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     wcnt_q;
  logic [CW-1:0]     n_q;
  logic [ADDR_W-1:0] base_q;
  logic              bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      wcnt_q <= '0;
      n_q    <= '0;
      base_q <= '0;
      bank_q <= 1'b0;
    end else if (line_start_i) begin
      act_q  <= fetch_en_i;
      cnt_q  <= '0;
      wcnt_q <= '0;
      n_q    <= CW'(line_bytes(HACT, mode_i));
      base_q <= ADDR_W'(src_row(32'(next_v_i), mode_i) * line_bytes(HACT, mode_i));
      bank_q <= next_v_i[0];
    end else begin
      if (act_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == n_q - 1'b1) act_q <= 1'b0;
      end
      if (mem_rvalid_i) wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign mem_req_o  = act_q;
  assign mem_addr_o = base_q + ADDR_W'(cnt_q);
  assign lb_we_o    = mem_rvalid_i;
  assign lb_waddr_o = (bank_q ? LBA'(HACT) : '0) + LBA'(wcnt_q);
  assign lb_wdata_o = mem_rdata_i;

  // R12
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && $past(mem_req_o) && !$past(line_start_i))
      |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));

  // R12
  resp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid_i |-> (wcnt_q < n_q));

endmodule

// File: rtl/vbm_linebuf.sv
module vbm_linebuf #(
  parameter int DEPTH = 1280,
  parameter int AW    = 11,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/vbm_palette.sv
module vbm_palette #(
  parameter int IDX_W = 8,
  parameter int COL_W = 12,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [COL_W-1:0] wdata_i,
  input  logic             act_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [COL_W-1:0] rgb_o
);

  logic [COL_W-1:0] tbl [ENTRIES];
  logic             hit;

  // Loading is allowed in reset so the table can be filled before start
  always_ff @(posedge clk) begin
    if (we_i) tbl[waddr_i] <= wdata_i;
  end

  assign hit = we_i && (waddr_i == idx_i);

  always_ff @(posedge clk) begin
    if (rst)         rgb_o <= '0;
    else if (!act_i) rgb_o <= '0;
    else if (hit)    rgb_o <= wdata_i;
    else             rgb_o <= tbl[idx_i];
  end

  // R9
  wr_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(we_i) && $past(act_i) && ($past(idx_i) == $past(waddr_i)))
      |-> (rgb_o == $past(wdata_i)));

endmodule

// File: rtl/vga_bitmap_ctrl.sv
module vga_bitmap_ctrl
  import vbm_pkg::*;
#(
  parameter int HACT   = 640,
  parameter int HFP    = 16,
  parameter int HSW    = 96,
  parameter int HBP    = 48,
  parameter int VACT   = 480,
  parameter int VFP    = 10,
  parameter int VSW    = 2,
  parameter int VBP    = 33,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_i,
  input  logic              pal_we_i,
  input  logic [7:0]        pal_waddr_i,
  input  logic [11:0]       pal_wdata_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [3:0]        red_o,
  output logic [3:0]        green_o,
  output logic [3:0]        blue_o,
  output logic              hsync_n_o,
  output logic              vsync_n_o
);

  localparam int HTOT = HACT + HFP + HSW + HBP;
  localparam int VTOT = VACT + VFP + VSW + VBP;
  localparam int HCW  = $clog2(HTOT);
  localparam int VCW  = $clog2(VTOT);
  localparam int LBD  = 2 * HACT;
  localparam int LBA  = $clog2(LBD);

  logic [HCW-1:0] h_cnt;
  logic [VCW-1:0] v_cnt;
  logic           line_start, last_line, disp_act, hs_raw, vs_raw;

  vbm_timing #(
    .HACT(HACT), .HFP(HFP), .HSW(HSW), .HBP(HBP),
    .VACT(VACT), .VFP(VFP), .VSW(VSW), .VBP(VBP)
  ) u_timing (
    .clk(clk), .rst(rst),
    .h_cnt_o(h_cnt), .v_cnt_o(v_cnt),
    .line_start_o(line_start), .last_line_o(last_line),
    .disp_act_o(disp_act), .hs_n_o(hs_raw), .vs_n_o(vs_raw)
  );

  // Frame-wide mode, taken when the fetch of line 0 starts
  vmode_t mode_in, frame_mode, fetch_mode;
  logic   frame_start;

  assign mode_in     = vmode_t'(mode_i);
  assign frame_start = line_start && last_line;
  assign fetch_mode  = frame_start ? mode_in : frame_mode;

  always_ff @(posedge clk) begin
    if (rst)              frame_mode <= '0;
    else if (frame_start) frame_mode <= mode_in;
  end

  logic [VCW-1:0] next_v;
  logic           fetch_en;
  assign next_v   = last_line ? '0 : v_cnt + 1'b1;
  assign fetch_en = (next_v < VCW'(VACT));

  logic           lb_we;
  logic [LBA-1:0] lb_waddr;
  logic [7:0]     lb_wdata;

  vbm_fetch #(
    .HACT(HACT), .VCW(VCW), .ADDR_W(ADDR_W), .LBA(LBA)
  ) u_fetch (
    .clk(clk), .rst(rst),
    .line_start_i(line_start), .next_v_i(next_v),
    .fetch_en_i(fetch_en), .mode_i(fetch_mode),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .lb_we_o(lb_we), .lb_waddr_o(lb_waddr), .lb_wdata_o(lb_wdata)
  );

  // Stage 0: buffer address from the raster position
  int unsigned    col;
  logic [LBA-1:0] rd_addr;
  logic           col_lsb;

  always_comb begin
    col     = src_col(32'(h_cnt), frame_mode);
    col_lsb = col[0];
    rd_addr = disp_act
            ? (v_cnt[0] ? LBA'(HACT) : '0) + LBA'(byte_of_col(col, frame_mode))
            : '0;
  end

  logic [7:0] lb_rdata;

  vbm_linebuf #(.DEPTH(LBD), .AW(LBA), .DW(8)) u_linebuf (
    .clk(clk), .we_i(lb_we), .waddr_i(lb_waddr), .wdata_i(lb_wdata),
    .raddr_i(rd_addr), .rdata_o(lb_rdata)
  );

  // Stage 1: side data aligned with the buffer read
  logic act1, lsb1, hs1, vs1;
  always_ff @(posedge clk) begin
    if (rst) begin
      act1 <= 1'b0; lsb1 <= 1'b0; hs1 <= 1'b1; vs1 <= 1'b1;
    end else begin
      act1 <= disp_act; lsb1 <= col_lsb; hs1 <= hs_raw; vs1 <= vs_raw;
    end
  end

  logic [7:0]  pix_idx;
  logic [11:0] rgb;
  assign pix_idx = index_of(lb_rdata, lsb1, frame_mode);

  // Stage 2: colour lookup, registered with the syncs
  vbm_palette #(.IDX_W(8), .COL_W(12)) u_palette (
    .clk(clk), .rst(rst),
    .we_i(pal_we_i), .waddr_i(pal_waddr_i), .wdata_i(pal_wdata_i),
    .act_i(act1), .idx_i(pix_idx), .rgb_o(rgb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n_o <= 1'b1; vsync_n_o <= 1'b1;
    end else begin
      hsync_n_o <= hs1; vsync_n_o <= vs1;
    end
  end

  assign red_o   = rgb[11:8];
  assign green_o = rgb[7:4];
  assign blue_o  = rgb[3:0];

  // R3
  blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(disp_act, 2) |-> ({red_o, green_o, blue_o} == 12'h000));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (v_cnt < VCW'(VACT)) |-> $stable(frame_mode));

endmodule

// File: tb/tb_vga_bitmap_ctrl.sv
module tb_vga_bitmap_ctrl;

  localparam int HACT = 16, HFP = 2, HSW = 3, HBP = 3;
  localparam int VACT = 8,  VFP = 1, VSW = 2, VBP = 2;
  localparam int HTOT = HACT + HFP + HSW + HBP;
  localparam int VTOT = VACT + VFP + VSW + VBP;
  localparam int AW   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0]    mode_drv;
  logic          pal_we;
  logic [7:0]    pal_waddr;
  logic [11:0]   pal_wdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid;
  logic [7:0]    mem_rdata;
  logic [3:0]    red, green, blue;
  logic          hs_n, vs_n;

  vga_bitmap_ctrl #(
    .HACT(HACT), .HFP(HFP), .HSW(HSW), .HBP(HBP),
    .VACT(VACT), .VFP(VFP), .VSW(VSW), .VBP(VBP), .ADDR_W(AW)
  ) dut (
    .clk(clk), .rst(rst), .mode_i(mode_drv),
    .pal_we_i(pal_we), .pal_waddr_i(pal_waddr), .pal_wdata_i(pal_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .red_o(red), .green_o(green), .blue_o(blue),
    .hsync_n_o(hs_n), .vsync_n_o(vs_n)
  );

  function automatic logic [7:0] mbyte(int a);
    return 8'(a * 29 + (a >> 3) + 5);
  endfunction

  function automatic logic [11:0] pval(int i);
    return 12'(i * 173 + 11);
  endfunction

  function automatic int bpl(logic [2:0] m);
    int w = m[0] ? HACT / 2 : HACT;
    return m[2] ? w : w / 2;
  endfunction

  // Memory model: two-cycle latency, in order
  logic          v1 = 1'b0, v2 = 1'b0;
  logic [AW-1:0] a1 = '0, a2 = '0;
  always @(posedge clk) begin
    v1 <= mem_req; a1 <= mem_addr;
    v2 <= v1;      a2 <= a1;
  end
  assign mem_rvalid = v2;
  assign mem_rdata  = mbyte(int'(a2));

  typedef struct {
    bit         act;
    logic [7:0] idx;
    logic       hs;
    logic       vs;
    int         row;
    string      tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [11:0] pal_m [256];
  int checks = 0, errors = 0;
  int bh, bv, fcount = 0, reqs = 0, cyc = 0;
  logic [2:0] bmode;
  bit done = 0;

  function automatic logic [2:0] sched(int k);
    case (k)
      0: return 3'b100;  // 8-bit, full size
      1: return 3'b000;  // 4-bit, full size
      2: return 3'b101;  // 8-bit, double width
      3: return 3'b110;  // 8-bit, double height
      4: return 3'b111;
      5: return 3'b011;  // 4-bit, both doubled
      default: return 3'b100;
    endcase
  endfunction

  // Driver: expected item for the current raster position
  task automatic push_expected();
    exp_t e;
    int sx, sy, b;
    e.act = (bh < HACT) && (bv < VACT);
    e.hs  = !((bh >= HACT + HFP) && (bh < HACT + HFP + HSW));
    e.vs  = !((bv >= VACT + VFP) && (bv < VACT + VFP + VSW));
    e.row = bv;
    e.idx = 8'h00;
    e.tag = "R3";
    if (e.act) begin
      sx = bmode[0] ? bh / 2 : bh;
      sy = bmode[1] ? bv / 2 : bv;
      b  = bmode[2] ? sx : sx / 2;
      if (bmode[2]) e.idx = mbyte(sy * bpl(bmode) + b);
      else begin
        logic [7:0] byt = mbyte(sy * bpl(bmode) + b);
        e.idx = (sx % 2 == 0) ? {4'h0, byt[7:4]} : {4'h0, byt[3:0]};
      end
      if (fcount == 7)      e.tag = "R10";
      else if (!bmode[2])   e.tag = "R5";
      else if (bmode[0])    e.tag = "R6";
      else if (bmode[1])    e.tag = "R7";
      else                  e.tag = "R4 R8";
    end
    exp_q.push_back(e);
  endtask

  // Monitor: oldest expected item against the outputs
  task automatic check_output();
    exp_t e;
    logic [11:0] want, got;
    string t;
    e    = exp_q.pop_front();
    want = e.act ? pal_m[e.idx] : 12'h000;
    got  = {red, green, blue};
    checks++;
    if (got !== want || hs_n !== e.hs || vs_n !== e.vs) begin
      errors++;
      if (hs_n !== e.hs)      t = "R1";
      else if (vs_n !== e.vs) t = "R2";
      else                    t = e.tag;
      $display("FAIL %s cyc %0d: rgb=%h hs=%b vs=%b expected rgb=%h hs=%b vs=%b",
               t, cyc, got, hs_n, vs_n, want, e.hs, e.vs);
    end
  endtask

  task automatic stimulus();
    pal_we = 1'b0;
    if (bh == 0 && bv == VTOT - 1) mode_drv = sched(fcount);
    // Mid-frame change must wait for the next frame
    if (fcount == 7 && bv == 3 && bh == 0) mode_drv = 3'b011;  // R10
    // Same-cycle write to the entry of the next outgoing pixel
    if (fcount == 8 && exp_q[0].act && exp_q[0].row == 2) begin
      pal_we    = 1'b1;
      pal_waddr = exp_q[0].idx;
      pal_wdata = pal_m[exp_q[0].idx] ^ 12'hA5A;
      pal_m[exp_q[0].idx] = pal_wdata;
      exp_q[0].tag = "R9";
    end
  endtask

  task automatic latch_frame();
    if (fcount >= 1) begin
      checks++;
      if (reqs != VACT * bpl(bmode)) begin
        errors++;
        $display("FAIL R12 frame %0d: reads=%0d expected %0d",
                 fcount - 1, reqs, VACT * bpl(bmode));
      end
    end
    reqs   = 0;
    bmode  = mode_drv;
    fcount = fcount + 1;
  endtask

  initial begin
    exp_t pre;
    mode_drv = 3'b100; pal_we = 1'b0; pal_waddr = '0; pal_wdata = '0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      pal_we = 1'b1; pal_waddr = 8'(i); pal_wdata = pval(i); pal_m[i] = pval(i);
    end
    @(negedge clk); pal_we = 1'b0;
    @(negedge clk);
    checks++;
    if ({red, green, blue} !== 12'h000 || hs_n !== 1'b1 || vs_n !== 1'b1) begin
      errors++;
      $display("FAIL R11 reset: rgb=%h hs=%b vs=%b expected rgb=000 hs=1 vs=1",
               {red, green, blue}, hs_n, vs_n);
    end
    pre.act = 0; pre.idx = 0; pre.hs = 1; pre.vs = 1; pre.row = -1; pre.tag = "R11";
    exp_q.push_back(pre);
    exp_q.push_back(pre);
    bmode = 3'b000;
    rst = 1'b0;
    bh = 0; bv = VTOT - 1;
    while (!done) begin
      cyc++;
      check_output();
      push_expected();
      stimulus();
      if (bh == 0 && bv == VTOT - 1) begin
        latch_frame();
        if (fcount == 10) done = 1;
      end
      if (mem_req === 1'b1) reqs++;
      if (bh == HTOT - 1) begin
        bh = 0;
        bv = (bv == VTOT - 1) ? 0 : bv + 1;
      end else bh++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog: run did not complete");
        done = 1;
      end
      if (!done) @(negedge clk);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: time limit reached");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule